// File: doc/BRIEF.md
# I2C bus clear engine

This block frees an I2C bus when a target device is stuck holding SDA low. Software stages a pulse threshold and two option bits in a configuration register. It copies them into the working (shadow) copy with a load strobe. It then sets the enable bit to start recovery. While recovery runs, the engine pulls SCL low and releases it, one pulse at a time, and samples SDA during each high phase.

The run ends early when the terminate option is set and SDA has been seen released. Otherwise it ends when the programmed number of pulses has been issued. If SDA finished high and the stop option is set, the engine then generates a STOP condition on the bus. The enable bit reads 1 for the whole run and clears itself at the end, so software can poll it. A status bit then tells whether SDA was freed.

Both bus lines are open-drain: the block only ever pulls a line low or releases it. The bus-rate divider lives outside the block and arrives as a one-cycle `tick` strobe. SDA passes through a synchronizer before it is used.

Top module: `i2c_bus_clear`

## Requirements
- R1: After reset SCL and SDA are released (`scl_oe`=0, `sda_oe`=0), and all three registers read 0.
- R2: Register word 0 is configuration: bits 23:16 hold the staged threshold, bit 2 the stop option, bit 1 the terminate option, and bit 0 the enable. Reading word 0 returns the staged fields, with bit 0 showing whether a run is active. Word 1 bit 0 is the load strobe. Word 2 bit 0 is the success status. All other bits read 0.
- R3: Staged values only take effect after a 1 is written to word 1 bit 0. That bit reads 1 until the shadow copy has been updated and 0 afterwards. If the strobe arrives while a run is active, the update waits until the run has ended.
- R4: Writing word 0 with bit 0 set while idle starts a run. Bit 0 reads 1 until the run ends and then reads 0. A write with bit 0 set during a run has no effect on that run.
- R5: Each recovery pulse drives SCL low for two ticks and then releases it for two ticks. SDA is sampled at the first tick of the released phase.
- R6: With terminate set, pulsing ends after the first pulse whose sample sees SDA high. No more than the threshold number of pulses is ever issued.
- R7: With terminate clear, exactly the threshold number of pulses is issued. The pulse count never exceeds the threshold.
- R8: Status is cleared when a run starts. At the end of the run it is set to 1 if the last SDA sample was high, and left at 0 if it was low.
- R9: With the stop option set and the last sample high, the engine follows the last pulse with a STOP: first SCL and SDA are pulled low (two ticks), then SCL is released with SDA held low (two ticks), then SDA is released while SCL is high. When the run fails, or the option is clear, no STOP is generated and SDA is never driven.
- R10: A run started with a shadow threshold of 0 issues no pulses. It ends in the same cycle it starts, and status takes the synchronized SDA level.
- R11: SCL and SDA are never driven while no run is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | One-cycle strobe from the external bus-rate divider |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word index, used for both write and read |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data for `reg_addr` (combinational) |
| sda_in | input | 1 | Sensed SDA line level (1 = high) |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
The assertions take for granted that `tick` is a single-cycle strobe, spaced far enough apart that the synchronized SDA settles within one tick period. They also assume the target changes SDA only while SCL is held low, and that register writes last one cycle each. The stimulus produces a tick every third cycle. It models the target as holding SDA low until it has seen a programmed number of SCL falling edges, so SDA is only ever released while SCL is low. Every register access is a single-cycle write or read driven on the falling clock edge.

// File: rtl/i2c_bc_pkg.sv
package i2c_bc_pkg;

  typedef enum logic [2:0] {
    BC_IDLE  = 3'd0,
    BC_PLOW  = 3'd1,
    BC_PHIGH = 3'd2,
    BC_SLOW  = 3'd3,
    BC_SHIGH = 3'd4
  } bc_state_e;

  localparam int ADDR_CFG  = 0;
  localparam int ADDR_LOAD = 1;
  localparam int ADDR_STAT = 2;

  localparam int CFG_EN_BIT   = 0;
  localparam int CFG_TERM_BIT = 1;
  localparam int CFG_STOP_BIT = 2;
  localparam int CFG_THR_LSB  = 16;
  localparam int LOAD_BIT     = 0;
  localparam int STAT_OK_BIT  = 0;

endpackage

// File: rtl/bc_sda_sync.sv
module bc_sda_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic line_sync
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[0] <= 1'b1;
          else        chain[0] <= line_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[g] <= 1'b1;
          else        chain[g] <= chain[g-1];
        end
      end
    end
  endgenerate

  assign line_sync = chain[STAGES-1];
endmodule

// File: rtl/bc_cfg_regs.sv
module bc_cfg_regs
  import i2c_bc_pkg::*;
#(
  parameter int THR_W  = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              busy,
  input  logic              status_ok,
  output logic [DATA_W-1:0] rdata,
  output logic              start_req,
  output logic [THR_W-1:0]  sh_thr,
  output logic              sh_term,
  output logic              sh_stop,
  output logic              load_pend
);
  localparam logic [DATA_W-1:0] THR_MASK  = {{(DATA_W-THR_W){1'b0}}, {THR_W{1'b1}}} << CFG_THR_LSB;
  localparam logic [DATA_W-1:0] USED_MASK = THR_MASK | DATA_W'(7);

  logic [THR_W-1:0] st_thr;
  logic             st_term;
  logic             st_stop;
  logic             wr_cfg;
  logic             wr_load;
  logic             unused_wdata_bits;

  function automatic logic [DATA_W-1:0] cfg_word(input logic [THR_W-1:0] thr,
                                                 input logic stop_o, input logic term_o,
                                                 input logic run);
    logic [DATA_W-1:0] w;
    w = '0;
    w[CFG_THR_LSB +: THR_W] = thr;
    w[CFG_STOP_BIT] = stop_o;
    w[CFG_TERM_BIT] = term_o;
    w[CFG_EN_BIT]   = run;
    return w;
  endfunction

  assign wr_cfg    = wr_en && (addr == ADDR_W'(ADDR_CFG));
  assign wr_load   = wr_en && (addr == ADDR_W'(ADDR_LOAD)) && wdata[LOAD_BIT];
  assign start_req = wr_cfg && wdata[CFG_EN_BIT] && !busy;
  assign unused_wdata_bits = ^(wdata & ~USED_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_thr  <= '0;
      st_term <= 1'b0;
      st_stop <= 1'b0;
    end else if (wr_cfg) begin
      st_thr  <= wdata[CFG_THR_LSB +: THR_W];
      st_term <= wdata[CFG_TERM_BIT];
      st_stop <= wdata[CFG_STOP_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_pend <= 1'b0;
      sh_thr    <= '0;
      sh_term   <= 1'b0;
      sh_stop   <= 1'b0;
    end else if (wr_load) begin
      load_pend <= 1'b1;
    end else if (load_pend && !busy) begin
      load_pend <= 1'b0;
      sh_thr    <= st_thr;
      sh_term   <= st_term;
      sh_stop   <= st_stop;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      ADDR_W'(ADDR_CFG):  rdata = cfg_word(st_thr, st_stop, st_term, busy);
      ADDR_W'(ADDR_LOAD): rdata[LOAD_BIT] = load_pend;
      ADDR_W'(ADDR_STAT): rdata[STAT_OK_BIT] = status_ok;
      default:            rdata = '0;
    endcase
  end
endmodule

// File: rtl/bc_engine.sv
module bc_engine
  import i2c_bc_pkg::*;
#(
  parameter int THR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             start,
  input  logic [THR_W-1:0] thr,
  input  logic             term,
  input  logic             stop_opt,
  input  logic             sda_hi,
  output bc_state_e        state,
  output logic             busy,
  output logic             status_ok,
  output logic [THR_W-1:0] pulse_cnt,
  output logic             pulse_end,
  output logic             sample_hi
);
  logic             half;
  logic [THR_W-1:0] cnt_next;
  logic             last_pulse;

  function automatic logic is_last(input logic [THR_W-1:0] done_cnt,
                                   input logic [THR_W-1:0] limit,
                                   input logic term_en, input logic seen_hi);
    return (done_cnt == limit) || (term_en && seen_hi);
  endfunction

  assign cnt_next   = pulse_cnt + 1'b1;
  assign pulse_end  = (state == BC_PHIGH) && tick && half;
  assign last_pulse = is_last(cnt_next, thr, term, sample_hi);
  assign busy       = (state != BC_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= BC_IDLE;
      half      <= 1'b0;
      pulse_cnt <= '0;
      status_ok <= 1'b0;
      sample_hi <= 1'b0;
    end else begin
      case (state)
        BC_IDLE: begin
          if (start) begin
            if (thr == '0) begin
              status_ok <= sda_hi;
            end else begin
              state     <= BC_PLOW;
              half      <= 1'b0;
              pulse_cnt <= '0;
              status_ok <= 1'b0;
              sample_hi <= 1'b0;
            end
          end
        end
        BC_PLOW: begin
          if (tick) begin
            half <= ~half;
            if (half) state <= BC_PHIGH;
          end
        end
        BC_PHIGH: begin
          if (tick) begin
            half <= ~half;
            if (!half) begin
              sample_hi <= sda_hi;
            end else begin
              pulse_cnt <= cnt_next;
              if (last_pulse) begin
                if (stop_opt && sample_hi) begin
                  state <= BC_SLOW;
                end else begin
                  state     <= BC_IDLE;
                  status_ok <= sample_hi;
                end
              end else begin
                state <= BC_PLOW;
              end
            end
          end
        end
        BC_SLOW: begin
          if (tick) begin
            half <= ~half;
            if (half) state <= BC_SHIGH;
          end
        end
        BC_SHIGH: begin
          if (tick) begin
            half <= ~half;
            if (half) begin
              state     <= BC_IDLE;
              status_ok <= sample_hi;
            end
          end
        end
        default: state <= BC_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bc_pin_ctrl.sv
module bc_pin_ctrl
  import i2c_bc_pkg::*;
(
  input  bc_state_e state,
  output logic      scl_oe,
  output logic      sda_oe
);
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (state)
      BC_PLOW:  scl_oe = 1'b1;
      BC_SLOW:  begin scl_oe = 1'b1; sda_oe = 1'b1; end
      BC_SHIGH: sda_oe = 1'b1;
      default:  begin scl_oe = 1'b0; sda_oe = 1'b0; end
    endcase
  end
endmodule

// File: rtl/i2c_bus_clear.sv
module i2c_bus_clear
  import i2c_bc_pkg::*;
#(
  parameter int THR_W       = 8,
  parameter int DATA_W      = 32,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              reg_wr_en,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe
);
  bc_state_e        state;
  logic             busy;
  logic             status_ok;
  logic             start_req;
  logic             load_pend;
  logic [THR_W-1:0] shadow_thr;
  logic             shadow_term;
  logic             shadow_stop;
  logic [THR_W-1:0] pulse_cnt;
  logic             pulse_end;
  logic             sample_hi;
  logic             sda_sync;

  bc_sda_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .line_in(sda_in), .line_sync(sda_sync)
  );

  bc_cfg_regs #(.THR_W(THR_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(reg_wr_en), .addr(reg_addr),
    .wdata(reg_wdata), .busy(busy), .status_ok(status_ok), .rdata(reg_rdata),
    .start_req(start_req), .sh_thr(shadow_thr), .sh_term(shadow_term),
    .sh_stop(shadow_stop), .load_pend(load_pend)
  );

  bc_engine #(.THR_W(THR_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .tick(tick), .start(start_req),
    .thr(shadow_thr), .term(shadow_term), .stop_opt(shadow_stop),
    .sda_hi(sda_sync), .state(state), .busy(busy), .status_ok(status_ok),
    .pulse_cnt(pulse_cnt), .pulse_end(pulse_end), .sample_hi(sample_hi)
  );

  bc_pin_ctrl u_pins (
    .state(state), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );
endmodule

// File: rtl/i2c_bus_clear_chk.sv
module i2c_bus_clear_chk #(
  parameter int THR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             start_req,
  input logic             load_pend,
  input logic             sample_hi,
  input logic             pulse_end,
  input logic [THR_W-1:0] pulse_cnt,
  input logic [THR_W-1:0] shadow_thr
);
  assert_idle_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!scl_oe && !sda_oe));

  assert_sda_under_scl_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> scl_oe);

  assert_stop_only_on_success_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> sample_hi);

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (pulse_cnt <= shadow_thr));

  assert_pulse_end_under_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pulse_end |-> (pulse_cnt < shadow_thr));

  assert_load_deferred_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_pend) |-> !$past(busy));

  assert_start_from_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start_req));
endmodule

bind i2c_bus_clear i2c_bus_clear_chk #(.THR_W(THR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .scl_oe(scl_oe), .sda_oe(sda_oe),
  .start_req(start_req), .load_pend(load_pend), .sample_hi(sample_hi),
  .pulse_end(pulse_end), .pulse_cnt(pulse_cnt), .shadow_thr(shadow_thr)
);

// File: tb/i2c_bus_clear_bench.sv
`timescale 1ns/1ps
module i2c_bus_clear_bench;
  localparam int A_CFG = 0, A_LOAD = 1, A_STAT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe, sda_in, tick;
  int          tick_div = 0;

  int n_chk = 0, n_fail = 0;
  int falls = 0, pulses = 0, stops = 0;
  int low_len = 0, high_len = 0, last_low = 0, last_high = 0;
  logic prev_scl = 1'b0, prev_sda = 1'b0;
  int base_falls = 0, target_k = 0;

  always #10 clk = ~clk;

  always @(posedge clk) tick_div <= (tick_div == 2) ? 0 : tick_div + 1;
  assign tick = (tick_div == 0);

  assign sda_in = !(sda_oe || ((falls - base_falls) < target_k));

  always @(posedge clk) begin
    prev_scl <= scl_oe;
    prev_sda <= sda_oe;
    if (scl_oe && !prev_scl) begin
      falls <= falls + 1;
      if (!sda_oe) pulses <= pulses + 1;
      low_len <= 1;
      last_high <= high_len;
    end else if (scl_oe) low_len <= low_len + 1;
    if (!scl_oe && prev_scl) begin
      last_low <= low_len;
      high_len <= 1;
    end else if (!scl_oe) high_len <= high_len + 1;
    if (prev_sda && !sda_oe && !scl_oe) stops <= stops + 1;
  end

  i2c_bus_clear u_i2c_bus_clear (
    .clk(clk), .rst_n(rst_n), .tick(tick), .reg_wr_en(reg_wr_en),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] cfgw(int thr, bit stp, bit term, bit en);
    return (32'(thr & 255) << 16) | (32'(stp) << 2) | (32'(term) << 1) | 32'(en);
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = 2'(a); reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 2'(a);
    #1 d = reg_rdata;
  endtask

  task automatic poll_clear(input int a);
    logic [31:0] d;
    for (int i = 0; i < 5000; i++) begin
      rd(a, d);
      if (d[0] == 1'b0) break;
    end
  endtask

  task automatic load_cfg(int thr, bit stp, bit term);
    wr(A_CFG, cfgw(thr, stp, term, 1'b0));
    wr(A_LOAD, 32'd1);
    poll_clear(A_LOAD);
  endtask

  task automatic run_case(int thr, int k, bit term, bit stp,
                          output int gp, output int gs, output int gst);
    logic [31:0] d;
    int p0, s0;
    load_cfg(thr, stp, term);
    base_falls = falls;
    target_k = k;
    repeat (4) @(negedge clk);
    p0 = pulses; s0 = stops;
    wr(A_CFG, cfgw(thr, stp, term, 1'b1));
    poll_clear(A_CFG);
    repeat (2) @(negedge clk);
    rd(A_STAT, d);
    gp = pulses - p0; gs = stops - s0; gst = int'(d[0]);
  endtask

  initial begin
    #(20ns * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int gp, gs, gst, ep, est, p0;
    int thr_set[5] = '{1, 2, 3, 5, 18};
    int k_set[7]   = '{0, 1, 2, 3, 4, 6, 20};

    repeat (3) @(negedge clk);
    // R1 reset state
    chk(scl_oe == 0 && sda_oe == 0, "R1 pins released", int'({scl_oe, sda_oe}), 0);
    rd(A_CFG, d);  chk(d == 0, "R1 cfg reads 0", int'(d), 0);
    rd(A_LOAD, d); chk(d == 0, "R1 load reads 0", int'(d), 0);
    rd(A_STAT, d); chk(d == 0, "R1 status reads 0", int'(d), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R2 staged readback
    wr(A_CFG, cfgw(8'hA5, 1'b1, 1'b1, 1'b0));
    rd(A_CFG, d); chk(d == 32'h00A50006, "R2 cfg readback", int'(d), 32'h00A50006);
    wr(A_CFG, 32'hFF00FFF8 | cfgw(8'h3C, 1'b0, 1'b1, 1'b0));
    rd(A_CFG, d); chk(d == 32'h003C0002, "R2 unused bits read 0", int'(d), 32'h003C0002);

    // R5 pulse timing, R7 count
    run_case(3, 20, 1'b0, 1'b0, gp, gs, gst);
    chk(gp == 3, "R7 count thr3", gp, 3);
    chk(last_low == 6, "R5 low phase cycles", last_low, 6);
    chk(last_high == 6, "R5 high phase cycles", last_high, 6);

    // R3 unloaded staging has no effect
    wr(A_CFG, cfgw(5, 1'b0, 1'b0, 1'b0));
    p0 = pulses;
    wr(A_CFG, cfgw(5, 1'b0, 1'b0, 1'b1));
    poll_clear(A_CFG);
    chk(pulses - p0 == 3, "R3 no load keeps old threshold", pulses - p0, 3);

    // R3 deferred load, R4 enable while busy ignored
    load_cfg(6, 1'b0, 1'b0);
    base_falls = falls; target_k = 20;
    repeat (4) @(negedge clk);
    p0 = pulses;
    wr(A_CFG, cfgw(6, 1'b0, 1'b0, 1'b1));
    rd(A_CFG, d); chk(d[0] == 1, "R4 enable reads 1 while running", int'(d[0]), 1);
    repeat (30) @(negedge clk);
    wr(A_CFG, cfgw(2, 1'b0, 1'b0, 1'b1));
    wr(A_LOAD, 32'd1);
    repeat (3) @(negedge clk);
    rd(A_LOAD, d); chk(d[0] == 1, "R3 load pending while busy", int'(d[0]), 1);
    poll_clear(A_CFG);
    chk(pulses - p0 == 6, "R3 R4 run unchanged by mid-run writes", pulses - p0, 6);
    poll_clear(A_LOAD);
    base_falls = falls;
    repeat (4) @(negedge clk);
    p0 = pulses;
    wr(A_CFG, cfgw(2, 1'b0, 1'b0, 1'b1));
    poll_clear(A_CFG);
    chk(pulses - p0 == 2, "R3 deferred load applied", pulses - p0, 2);

    // R10 threshold zero
    run_case(0, 0, 1'b0, 1'b1, gp, gs, gst);
    chk(gp == 0 && gs == 0, "R10 zero threshold no pulses", gp + gs, 0);
    chk(gst == 1, "R10 zero threshold status SDA high", gst, 1);
    run_case(0, 5, 1'b0, 1'b0, gp, gs, gst);
    chk(gst == 0, "R10 zero threshold status SDA low", gst, 0);

    // Sweep: R6 R7 R8 R9
    foreach (thr_set[ti]) foreach (k_set[ki])
      for (int term = 0; term < 2; term++)
        for (int stp = 0; stp < 2; stp++) begin
          int t = thr_set[ti];
          int k = k_set[ki];
          est = (k <= t) ? 1 : 0;
          if (term == 1) ep = (((k < 1) ? 1 : k) < t) ? ((k < 1) ? 1 : k) : t;
          else ep = t;
          run_case(t, k, 1'(term), 1'(stp), gp, gs, gst);
          chk(gp == ep, (term == 1) ? "R6 terminate pulse count" : "R7 full pulse count", gp, ep);
          chk(gst == est, "R8 status result", gst, est);
          chk(gs == ((stp == 1 && est == 1) ? 1 : 0), "R9 stop generation", gs,
              (stp == 1 && est == 1) ? 1 : 0);
        end

    // R11 idle release after all runs
    chk(scl_oe == 0 && sda_oe == 0, "R11 idle pins released", int'({scl_oe, sda_oe}), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule